// File: doc/BRIEF.md
# Chip-Select Access Controller with Wait States

This block is a single chip-select channel of an external bus controller. An internal bus master presents a request (channel select, read/write direction, strobe) and holds it until it sees a response. The channel keeps a 32-bit configuration word, loaded through a load strobe. Depending on the direction and the channel's protection flags, it either drives its chip-select output for a programmed number of clock cycles and acknowledges in the last of them, or refuses the access and never touches the peripheral.

A refused access is answered one cycle after it is accepted. The answer is a transfer error when the bus-error enable is set and a plain acknowledge otherwise, so the master always receives exactly one response. Independently, an interrupt pulse is raised when the interrupt enable is set. The number of active cycles comes from two 8-bit fields, a prescale field and a base field. A 2-bit wait type picks either field alone or their product. Two special bus modes are decoded from the address-size and data-size fields of the configuration.

Top module: `cs_access_ctrl`

## Requirements
- R1: After reset the configuration word is 0x0000_0001, so only the read-only flag (bit 0) is set. Chip select, acknowledge, transfer error and interrupt outputs are all low.
- R2: Configuration layout: prescale count in bits [31:24], base count in bits [23:16], address size in [11:10], data size in [9:8], wait type in [5:4], write-only flag in bit 1, read-only flag in bit 0. A word presented with `cfg_load` high is in effect from the next cycle.
- R3: Wait type 2'b00: chip select stays high for the base count in cycles, or for 1 cycle when the base count is 0.
- R4: Wait type 2'b01: chip select stays high for the prescale count in cycles, or for 1 cycle when the prescale count is 0.
- R5: Wait type 2'b10: chip select stays high for (prescale+1)×(base+1) cycles.
- R6: Wait type 2'b11 behaves exactly like 2'b00.
- R7: A permitted access raises chip select in the cycle after the request is accepted. Chip select stays high without gaps, and the acknowledge is high only in the last active cycle.
- R8: With the write-only flag set, a read never raises chip select.
- R9: With the read-only flag set, a write never raises chip select.
- R10: A blocked access is answered in the cycle after acceptance. The answer is a transfer error if `berr_en` is high and an acknowledge otherwise. Acknowledge and transfer error are never high together.
- R11: A blocked access pulses `irq_o` for exactly one cycle, the response cycle, when `irq_en` is high. Otherwise the interrupt stays low. Permitted accesses never raise it.
- R12: A request is not accepted while an access is in progress. A strobe held through a response starts the next access only after one cycle with chip select low.
- R13: `large_flash_o` is high exactly when address size is 2'b11 and data size is 2'b00 or 2'b01.
- R14: `alt_mode_o` is high exactly when address size is 2'b10 and data size is 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load the configuration word |
| cfg_wdata | input | 32 | Configuration word to load |
| berr_en | input | 1 | Report blocked accesses as transfer errors |
| irq_en | input | 1 | Pulse the interrupt on blocked accesses |
| req_sel | input | 1 | Address decode hit for this channel |
| req_stb | input | 1 | Request strobe, held until a response |
| req_rd | input | 1 | 1 = read, 0 = write |
| cs_act_o | output | 1 | Chip select, active high |
| ack_o | output | 1 | Access acknowledge |
| xfer_err_o | output | 1 | Transfer error response |
| irq_o | output | 1 | Single-cycle protection interrupt |
| large_flash_o | output | 1 | Large-flash bus mode decoded |
| alt_mode_o | output | 1 | Alternate bus mode decoded |

## Verification
The hardest situation to reach from the ports is a strobe that stays high across a response. The master must not get a second, overlapping access, and the next one may start only after a cycle with chip select low. The bench reaches it by leaving the strobe asserted after the acknowledge and then checking the idle cycle and the length of the next burst. The full protection matrix is swept over direction, both flags and both enables. Every wait type is swept over small count grids, including zero counts.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;
  localparam int CFG_W     = 32;
  localparam int AS_LSB    = 10;
  localparam int DS_LSB    = 8;
  localparam int WT_LSB    = 4;
  localparam int WO_BIT    = 1;
  localparam int RO_BIT    = 0;
  localparam logic [CFG_W-1:0] CFG_RST = 32'h0000_0001;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_RESP   = 2'd2
  } cs_state_e;

  typedef enum logic [1:0] {
    WT_BASE     = 2'b00,
    WT_PRESC    = 2'b01,
    WT_PRODUCT  = 2'b10,
    WT_RESERVED = 2'b11
  } wait_type_e;
endpackage

// File: rtl/cs_cfg_reg.sv
`timescale 1ns/1ps
module cs_cfg_reg #(
  parameter int                WIDTH = 32,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else if (load) q <= q_d;
  end
endmodule

// File: rtl/cs_wait_calc.sv
`timescale 1ns/1ps
module cs_wait_calc
  import cs_pkg::*;
#(
  parameter int WAIT_W = 8,
  localparam int CNT_W = 2 * WAIT_W
) (
  input  logic [WAIT_W-1:0] wait_p,
  input  logic [WAIT_W-1:0] wait_x,
  input  logic [1:0]        wtype,
  output logic [CNT_W-1:0]  last_idx
);
  logic [CNT_W+1:0] prod;
  logic [CNT_W+1:0] prod_m1;
  logic [CNT_W-1:0] x_m1;
  logic [CNT_W-1:0] p_m1;

  always_comb begin
    prod    = ({{(WAIT_W+2){1'b0}}, wait_p} + 1'b1) * ({{(WAIT_W+2){1'b0}}, wait_x} + 1'b1);
    prod_m1 = prod - 1'b1;
    x_m1    = (wait_x == '0) ? '0 : {{WAIT_W{1'b0}}, wait_x} - 1'b1;
    p_m1    = (wait_p == '0) ? '0 : {{WAIT_W{1'b0}}, wait_p} - 1'b1;
    case (wait_type_e'(wtype))
      WT_PRESC:   last_idx = p_m1;
      WT_PRODUCT: last_idx = prod_m1[CNT_W-1:0];
      default:    last_idx = x_m1;
    endcase
  end
endmodule

// File: rtl/cs_mode_dec.sv
`timescale 1ns/1ps
module cs_mode_dec (
  input  logic [1:0] addr_sz,
  input  logic [1:0] data_sz,
  output logic       large_flash,
  output logic       alt_mode
);
  always_comb begin
    large_flash = (addr_sz == 2'b11) && !data_sz[1];
    alt_mode    = (addr_sz == 2'b10) && (data_sz == 2'b11);
  end
endmodule

// File: rtl/cs_access_seq.sv
`timescale 1ns/1ps
module cs_access_seq
  import cs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_rd,
  input  logic             wr_only,
  input  logic             rd_only,
  input  logic             berr_en,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] last_idx,
  output logic             cs_act,
  output logic             ack,
  output logic             xfer_err,
  output logic             irq,
  output logic             accept,
  output logic             blocked
);
  cs_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             err_q, err_d;
  logic             irq_q, irq_d;
  logic             bak_q, bak_d;

  always_comb begin
    accept  = req_valid && (state_q == ST_IDLE);
    blocked = req_rd ? wr_only : rd_only;
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (blocked) begin
            state_d = ST_RESP;
          end else begin
            state_d = ST_ACTIVE;
            cnt_d   = last_idx;
            cnt_en  = 1'b1;
          end
        end
      end
      ST_ACTIVE: begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    err_d = accept && blocked && berr_en;
    bak_d = accept && blocked && !berr_en;
    irq_d = accept && blocked && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      bak_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      bak_q   <= bak_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    cs_act   = (state_q == ST_ACTIVE);
    ack      = (cs_act && (cnt_q == '0)) || bak_q;
    xfer_err = err_q;
    irq      = irq_q;
  end
endmodule

// File: rtl/cs_access_ctrl.sv
`timescale 1ns/1ps
module cs_access_ctrl
  import cs_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_load,
  input  logic [31:0] cfg_wdata,
  input  logic        berr_en,
  input  logic        irq_en,
  input  logic        req_sel,
  input  logic        req_stb,
  input  logic        req_rd,
  output logic        cs_act_o,
  output logic        ack_o,
  output logic        xfer_err_o,
  output logic        irq_o,
  output logic        large_flash_o,
  output logic        alt_mode_o
);
  localparam int CNT_W  = 2 * WAIT_W;
  localparam int P_MSB  = CFG_W - 1;
  localparam int X_MSB  = CFG_W - 1 - WAIT_W;

  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] last_idx;
  logic             req_accept;
  logic             req_blocked;

  cs_cfg_reg #(.WIDTH(CFG_W), .RST_VAL(CFG_RST)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  cs_wait_calc #(.WAIT_W(WAIT_W)) u_wait (
    .wait_p   (cfg_q[P_MSB -: WAIT_W]),
    .wait_x   (cfg_q[X_MSB -: WAIT_W]),
    .wtype    (cfg_q[WT_LSB +: 2]),
    .last_idx (last_idx)
  );

  cs_mode_dec u_mode (
    .addr_sz     (cfg_q[AS_LSB +: 2]),
    .data_sz     (cfg_q[DS_LSB +: 2]),
    .large_flash (large_flash_o),
    .alt_mode    (alt_mode_o)
  );

  cs_access_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_sel && req_stb),
    .req_rd    (req_rd),
    .wr_only   (cfg_q[WO_BIT]),
    .rd_only   (cfg_q[RO_BIT]),
    .berr_en   (berr_en),
    .irq_en    (irq_en),
    .last_idx  (last_idx),
    .cs_act    (cs_act_o),
    .ack       (ack_o),
    .xfer_err  (xfer_err_o),
    .irq       (irq_o),
    .accept    (req_accept),
    .blocked   (req_blocked)
  );
endmodule

// File: rtl/cs_access_ctrl_chk.sv
`timescale 1ns/1ps
module cs_access_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic berr_en,
  input logic irq_en,
  input logic cs_act_o,
  input logic ack_o,
  input logic xfer_err_o,
  input logic irq_o,
  input logic large_flash_o,
  input logic alt_mode_o,
  input logic req_accept,
  input logic req_blocked
);
  AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && xfer_err_o)); // R10

  AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err_o |-> $past(berr_en)); // R10

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R11

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(irq_en) && !cs_act_o)); // R11

  AST_BLOCK_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_accept && req_blocked) |=> (!cs_act_o && (ack_o || xfer_err_o))); // R8

  AST_ACK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && cs_act_o) |=> !cs_act_o); // R7

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act_o |-> !req_accept); // R12

  AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(large_flash_o && alt_mode_o)); // R13
endmodule

bind cs_access_ctrl cs_access_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .berr_en       (berr_en),
  .irq_en        (irq_en),
  .cs_act_o      (cs_act_o),
  .ack_o         (ack_o),
  .xfer_err_o    (xfer_err_o),
  .irq_o         (irq_o),
  .large_flash_o (large_flash_o),
  .alt_mode_o    (alt_mode_o),
  .req_accept    (req_accept),
  .req_blocked   (req_blocked)
);

// File: tb/cs_access_ctrl_tb.sv
`timescale 1ns/1ps
module cs_access_ctrl_tb;
  logic        clk;
  logic        rst_n;
  logic        cfg_load;
  logic [31:0] cfg_wdata;
  logic        berr_en, irq_en, req_sel, req_stb, req_rd;
  logic        cs_act_o, ack_o, xfer_err_o, irq_o, large_flash_o, alt_mode_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  cs_access_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_wdata(cfg_wdata),
    .berr_en(berr_en), .irq_en(irq_en), .req_sel(req_sel), .req_stb(req_stb),
    .req_rd(req_rd), .cs_act_o(cs_act_o), .ack_o(ack_o), .xfer_err_o(xfer_err_o),
    .irq_o(irq_o), .large_flash_o(large_flash_o), .alt_mode_o(alt_mode_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int p, input int x, input int wt,
                                     input int as, input int ds, input bit wo, input bit ro);
    return {p[7:0], x[7:0], 4'b0, as[1:0], ds[1:0], 2'b0, wt[1:0], 2'b0, wo, ro};
  endfunction

  function automatic int exp_len(input int p, input int x, input int wt);
    case (wt)
      1:       return (p == 0) ? 1 : p;
      2:       return (p + 1) * (x + 1);
      default: return (x == 0) ? 1 : x;
    endcase
  endfunction

  task automatic load_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_load = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // Runs one access; returns observed chip-select cycles, response kind, irq cycles.
  task automatic access(input bit rd, input bit keep, output int n_cs, output bit got_ack,
                        output bit got_err, output int n_irq, output bit ack_with_cs,
                        output bit gap_ok);
    n_cs = 0; got_ack = 0; got_err = 0; n_irq = 0; ack_with_cs = 0;
    @(negedge clk);
    req_sel = 1'b1; req_stb = 1'b1; req_rd = rd;
    for (int i = 0; i < 70000; i++) begin
      @(posedge clk); #1;
      if (cs_act_o) n_cs++;
      if (irq_o) n_irq++;
      if (ack_o || xfer_err_o) begin
        got_ack = ack_o; got_err = xfer_err_o; ack_with_cs = cs_act_o;
        break;
      end
    end
    @(negedge clk);
    if (!keep) begin req_stb = 1'b0; req_sel = 1'b0; end
    @(posedge clk); #1;
    gap_ok = !cs_act_o && !ack_o && !xfer_err_o;
    if (irq_o) n_irq++;
  endtask

  task automatic run_len(input int p, input int x, input int wt, input string req);
    int n; bit a, e, awc, g; int q;
    load_cfg(mk(p, x, wt, 0, 0, 0, 0));
    access(1'b1, 1'b0, n, a, e, q, awc, g);
    check(n == exp_len(p, x, wt), req, n, exp_len(p, x, wt));
    check(a && !e && awc && g, "R7", {a, e, awc, g}, 4'b1011);
  endtask

  initial begin
    int n; bit a, e, awc, g; int q;
    rst_n = 1'b0; cfg_load = 0; cfg_wdata = 0; berr_en = 0; irq_en = 0;
    req_sel = 0; req_stb = 0; req_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!cs_act_o && !ack_o && !xfer_err_o && !irq_o, "R1 outputs", cs_act_o, 0);
    check(!large_flash_o && !alt_mode_o, "R1 modes", large_flash_o, 0);
    // R1/R9: reset word is read-only; a write is refused with an error when enabled.
    berr_en = 1; irq_en = 1;
    access(1'b0, 1'b0, n, a, e, q, awc, g);
    check(n == 0 && e && !a && q == 1, "R1 read-only at reset", n, 0);
    // Read at reset is permitted, single cycle (all counts zero).
    access(1'b1, 1'b0, n, a, e, q, awc, g);
    check(n == 1 && a && q == 0, "R1 zero count", n, 1);

    // R3..R6 wait-type sweeps
    for (int x = 0; x < 10; x++) run_len(3, x, 0, "R3");
    for (int p = 0; p < 10; p++) run_len(p, 7, 1, "R4");
    for (int p = 0; p < 5; p++)
      for (int x = 0; x < 5; x++) run_len(p, x, 2, "R5");
    run_len(15, 15, 2, "R5");
    run_len(255, 0, 1, "R4");
    for (int x = 0; x < 6; x++) run_len(3, x, 3, "R6");

    // R2: field positions, each count field alone
    run_len(0, 200, 0, "R2");
    run_len(9, 0, 1, "R2");

    // R8..R11 protection matrix
    for (int k = 0; k < 32; k++) begin
      bit rd, wo, ro, be, ie, blk;
      rd = k[0]; wo = k[1]; ro = k[2]; be = k[3]; ie = k[4];
      blk = rd ? wo : ro;
      load_cfg(mk(0, 2, 0, 0, 0, wo, ro));
      berr_en = be; irq_en = ie;
      access(rd, 1'b0, n, a, e, q, awc, g);
      check(n == (blk ? 0 : 2), rd ? "R8" : "R9", n, blk ? 0 : 2);
      check(e == (blk && be) && a == !(blk && be), "R10", {a, e}, {!(blk && be), blk && be});
      check(q == ((blk && ie) ? 1 : 0), "R11", q, (blk && ie) ? 1 : 0);
    end
    berr_en = 0; irq_en = 0;

    // R12: strobe held across responses
    load_cfg(mk(0, 3, 0, 0, 0, 0, 0));
    access(1'b1, 1'b1, n, a, e, q, awc, g);
    check(n == 3 && g, "R12 first burst and gap", n, 3);
    access(1'b1, 1'b1, n, a, e, q, awc, g);
    check(n == 3 && a && g, "R12 second burst", n, 3);
    access(1'b0, 1'b0, n, a, e, q, awc, g);
    check(n == 3 && a, "R12 third burst", n, 3);
    // deselected strobe is ignored
    @(negedge clk); req_stb = 1; req_sel = 0;
    repeat (3) @(posedge clk); #1;
    check(!cs_act_o && !ack_o, "R12 no select", cs_act_o, 0);
    @(negedge clk); req_stb = 0;

    // R13/R14 mode decode
    for (int as = 0; as < 4; as++)
      for (int ds = 0; ds < 4; ds++) begin
        load_cfg(mk(0, 0, 0, as, ds, 0, 0));
        check(large_flash_o == (as == 3 && ds < 2), "R13", large_flash_o, as == 3 && ds < 2);
        check(alt_mode_o == (as == 2 && ds == 3), "R14", alt_mode_o, as == 2 && ds == 3);
      end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule